// File: doc/BRIEF.md
# Indirect PHY Delay Register Port

This block gives software access to a bank of 64 eight-bit PHY delay registers through a single 32-bit control word. The control word holds a register index, a byte to write, a byte read back, two request flags and an acknowledge flag. Software never addresses a PHY register directly. It loads the index and data with both requests clear, then raises a request and waits for acknowledge. It then clears the request, which lets acknowledge fall and closes a four-phase handshake.

The bank stands in for a PHY on a slower clock. Every request therefore waits a fixed number of cycles before it is served. Typical contents are input delays per bus mode at indices 0x00 to 0x08. The clock, high-speed clock and strobe delay-line settings sit at 0x0B, 0x0C and 0x0D. Any of the 64 indices can be written and read.

Top module: `phy_port`

## Requirements
- R1: After reset the control word reads as all zeros, and every PHY register reads back as 0x00.
- R2: The control word layout is fixed as follows. Bits [5:0] hold the register index and bits [15:8] the write byte. Bits [23:16] hold the read byte. Bit 24 is the write request, bit 25 the read request and bit 26 the acknowledge. Bits [7:6] and [31:27] read as zero. Bus writes to the read byte or to the acknowledge bit have no effect.
- R3: A write request stores the write byte into the indexed PHY register and then raises acknowledge.
- R4: Acknowledge rises exactly LAT+1 clock edges after the edge that registers a request. LAT is a parameter, at least 2, with a default of 2.
- R5: Acknowledge stays high for as long as either request bit is high.
- R6: Acknowledge falls on the first clock edge after both request bits are seen clear.
- R7: A read request copies the indexed register into the read byte no later than the edge that raises acknowledge. The read byte then keeps its value until the next read completes, and writes do not change it.
- R8: When both request bits are raised together, only the write is performed and the read byte is left unchanged.
- R9: Once a transfer starts, its index, data and type are fixed. Bus writes made before acknowledge falls neither alter it nor start a second transfer.
- R10: The 64 registers are independent. A write changes only the indexed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Load the control word from bus_wdata |
| bus_wdata | input | 32 | Control word written by software |
| bus_rdata | output | 32 | Current control word, including read byte and acknowledge |

## Verification
Directed transfers to the delay-line indices are the base cases. They separate a correct write from an acknowledge that rises without the register being updated. They also show whether acknowledge rises on the exact cycle and falls on the exact cycle. A read between two writes shows whether the read byte is captured once and then held. A request with both bits set tells a write-wins policy apart from a read or from both actions. Bus writes placed while a transfer is busy or acknowledged show whether the transfer was latched at its start. A long random mix of writes, reads and combined requests over all 64 indices, compared with a bench model, exposes any aliasing between entries.

// File: rtl/phy_port.sv
module phy_port #(
  parameter int LAT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int AW   = 6;
  localparam int DW   = 8;
  localparam int NREG = 1 << AW;
  localparam int CW   = $clog2(LAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_ACK} st_t;
  st_t st;

  logic [AW-1:0] addr_q, cmd_addr;
  logic [DW-1:0] wdat_q, cmd_wdat, rdat_q;
  logic          wreq_q, rreq_q, ack_q, cmd_wr;
  logic [CW-1:0] cnt;
  logic [DW-1:0] mem [NREG];

  wire req  = wreq_q | rreq_q;
  wire fire = (st == S_BUSY) && (cnt == CW'(LAT - 1));

  assign bus_rdata = {5'd0, ack_q, rreq_q, wreq_q, rdat_q, wdat_q, 2'd0, addr_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
      wreq_q <= 1'b0;
      rreq_q <= 1'b0;
    end else if (bus_we) begin
      addr_q <= bus_wdata[5:0];
      wdat_q <= bus_wdata[15:8];
      wreq_q <= bus_wdata[24];
      rreq_q <= bus_wdata[25];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ack_q    <= 1'b0;
      cmd_addr <= '0;
      cmd_wdat <= '0;
      cmd_wr   <= 1'b0;
      rdat_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          st       <= S_BUSY;
          cnt      <= '0;
          cmd_addr <= addr_q;
          cmd_wdat <= wdat_q;
          cmd_wr   <= wreq_q;
        end
        S_BUSY: if (fire) begin
          st    <= S_ACK;
          ack_q <= 1'b1;
          if (!cmd_wr) rdat_q <= mem[cmd_addr];
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_ACK: if (!req) begin
          st    <= S_IDLE;
          ack_q <= 1'b0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (fire && cmd_wr) begin
      mem[cmd_addr] <= cmd_wdat;
    end
  end

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && req) |=> ack_q); // R5
  AST_ACK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && !req) |=> !ack_q); // R6
  AST_MIN_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> ($past(st == S_BUSY, 1) && $past(st == S_BUSY, 2))); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdat_q) |-> $rose(ack_q)); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> (st != S_BUSY)); // R9
endmodule

// File: tb/phy_port_tb.sv
module phy_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] mdl [64];
  logic [7:0] last_rd = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_port #(.LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] pack(input logic [5:0] a, input logic [7:0] d,
                                       input logic wr, input logic rd);
    return {5'd0, 1'b0, rd, wr, 8'd0, d, 2'd0, a};
  endfunction

  function automatic logic [31:0] expect_word(input logic [5:0] a, input logic [7:0] d,
                                              input logic wr, input logic rd,
                                              input logic [7:0] r, input logic ack);
    return {5'd0, ack, rd, wr, r, d, 2'd0, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] w);
    @(negedge clk);
    bus_we = 1'b1;
    bus_wdata = w;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wait_ack(output int n);
    n = 0;
    while (!bus_rdata[26] && n < 50) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic xfer(input logic [5:0] a, input logic [7:0] d, input logic wr,
                      input logic rd, input bit verbose);
    int n;
    bus_wr(pack(a, d, 1'b0, 1'b0));
    bus_wr(pack(a, d, wr, rd));
    wait_ack(n);
    if (verbose) chk(n == LAT + 1, "R4 latency", 32'(n), 32'(LAT + 1));
    if (wr) mdl[a] = d;
    else if (rd) last_rd = mdl[a];
    bus_wr(pack(a, d, 1'b0, 1'b0));
    if (verbose) chk(bus_rdata[26] == 1'b1, "R5 ack held until clear seen", 32'(bus_rdata[26]), 32'd1);
    @(negedge clk);
    if (verbose) chk(bus_rdata[26] == 1'b0, "R6 ack falls", 32'(bus_rdata[26]), 32'd0);
  endtask

  task automatic rd_chk(input logic [5:0] a, input string tag);
    xfer(a, 8'h00, 1'b0, 1'b1, 1'b0);
    chk(bus_rdata[23:16] == mdl[a], tag, 32'(bus_rdata[23:16]), 32'(mdl[a]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk(bus_rdata == 32'd0, "R1 reset word", bus_rdata, 32'd0);
    rd_chk(6'h0D, "R1 reset register value");

    // R2 layout and ignored fields
    bus_wr(32'hFC_FF_5A_C7 & ~32'h0300_0000);
    chk(bus_rdata == expect_word(6'h07, 8'h5A, 1'b0, 1'b0, last_rd, 1'b0),
        "R2 layout, read byte and ack not writable", bus_rdata,
        expect_word(6'h07, 8'h5A, 1'b0, 1'b0, last_rd, 1'b0));

    // R3 / R4 / R5 / R6 directed write to delay-line index
    xfer(6'h0B, 8'hA5, 1'b1, 1'b0, 1'b1);
    rd_chk(6'h0B, "R3 write stored");
    xfer(6'h0C, 8'h3E, 1'b1, 1'b0, 1'b1);
    xfer(6'h08, 8'h11, 1'b1, 1'b0, 1'b1);

    // R5 ack held for several cycles
    bus_wr(pack(6'h0D, 8'h77, 1'b0, 1'b0));
    bus_wr(pack(6'h0D, 8'h77, 1'b1, 1'b0));
    wait_ack(n);
    mdl[6'h0D] = 8'h77;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(bus_rdata[26] == 1'b1, "R5 ack stays high", 32'(bus_rdata[26]), 32'd1);
    end
    bus_wr(pack(6'h0D, 8'h77, 1'b0, 1'b0));
    @(negedge clk);
    chk(bus_rdata[26] == 1'b0, "R6 ack drops", 32'(bus_rdata[26]), 32'd0);

    // R7 read held across a later write
    rd_chk(6'h0C, "R7 read byte captured");
    xfer(6'h20, 8'hC3, 1'b1, 1'b0, 1'b0);
    chk(bus_rdata[23:16] == 8'h3E, "R7 read byte held after write", 32'(bus_rdata[23:16]), 32'h3E);

    // R8 write wins over read
    xfer(6'h03, 8'h3C, 1'b1, 1'b1, 1'b0);
    chk(bus_rdata[23:16] == 8'h3E, "R8 read byte untouched", 32'(bus_rdata[23:16]), 32'h3E);
    rd_chk(6'h03, "R8 write performed");

    // R9 changes while busy are ignored
    bus_wr(pack(6'h10, 8'h99, 1'b0, 1'b0));
    bus_wr(pack(6'h10, 8'h99, 1'b1, 1'b0));
    bus_wr(pack(6'h11, 8'h44, 1'b1, 1'b0));
    wait_ack(n);
    mdl[6'h10] = 8'h99;
    // R9 changes while acknowledged are ignored
    bus_wr(pack(6'h12, 8'h55, 1'b1, 1'b0));
    chk(bus_rdata[26] == 1'b1, "R9 ack unaffected", 32'(bus_rdata[26]), 32'd1);
    bus_wr(pack(6'h12, 8'h55, 1'b0, 1'b0));
    @(negedge clk);
    rd_chk(6'h10, "R9 latched transfer used");
    rd_chk(6'h11, "R9 busy change ignored");
    rd_chk(6'h12, "R9 acked change ignored");

    // R10 random mix against model
    for (int k = 0; k < 300; k++) begin
      logic [5:0] a;
      logic [7:0] d;
      int op;
      a = 6'($urandom_range(63));
      d = 8'($urandom_range(255));
      op = $urandom_range(2);
      if (op == 0) xfer(a, d, 1'b1, 1'b0, 1'b0);
      else if (op == 1) xfer(a, d, 1'b1, 1'b1, 1'b0);
      else begin
        xfer(a, d, 1'b0, 1'b1, 1'b0);
      end
      chk(bus_rdata[23:16] == last_rd, "R10 read byte vs model",
          32'(bus_rdata[23:16]), 32'(last_rd));
    end
    for (int i = 0; i < 64; i++) rd_chk(6'(i), "R10 final sweep");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule